// File: doc/BRIEF.md
# Sub-Audible Sine Tone Generator

This block feeds the second 8-bit channel of a digital-to-analog converter. It has two sources for that channel. In direct mode the channel carries a byte that the CPU writes to a data register. In tone mode it carries samples from a 64-point, 8-bit sine table. A down-counting 10-bit reload timer steps through that table. The timer advances once every two input clocks, so the tone it produces is a low, sub-audible frequency.

The CPU sets up the block through a small register write port with four locations:

| Address | Contents |
|---------|----------|
| 0 | Control |
| 1 | Low eight bits of the timer reload value |
| 2 | High two bits of the timer reload value |
| 3 | Direct data byte |

The control byte holds three bits. Bit 0 is the tone/direct select. Bit 1 is a write-timing bit, which decides whether a new reload value also restarts the running count. Bit 2 is the output enable.

When the channel is disabled, the code output is forced to zero and a separate high-impedance request is raised. The pad logic uses that request.

Top module: `subtone_gen`

## Requirements
- R1: After reset the code output is 0, the output enable is 0, the high-impedance request is 1, the data register holds 0x00 and the block is in direct mode.
- R2: While control bit 2 (output enable) is 0, the code output is 0 and the high-impedance request is 1. While it is 1, the high-impedance request is 0.
- R3: In direct mode (control bit 0 = 0) with the output enabled, the code output equals the last byte written to address 3. It updates on the clock edge that takes the write.
- R4: In tone mode the code output for table address a is 128 + round(127·sin(2πa/64)). This value is always in the range 1..255.
- R5: While in direct mode the table address is held at 0, the timer is held at the reload value and the half-rate divider is held at its start phase. As a result, the write that sets bit 0 shows address 0 at once, and the first step comes 2·(L+1) clocks after that write.
- R6: In tone mode the table address increments once every 2·(L+1) clocks and wraps from 63 to 0. Here L is the 10-bit reload value.
- R7: With control bit 1 = 0, a reload write changes only the latch. The running period ends on its old schedule, and the new length applies from the next period on.
- R8: With control bit 1 = 1, a reload write also restarts the count. The next step comes 2·(L+1)+1 clocks after the write edge.
- R9: A write to address 3 in tone mode leaves the code output unchanged. The written byte appears once direct mode is selected again.
- R10: The reload value is 10 bits wide. Address 1 holds bits 7..0, and bits 1..0 of address 2 hold bits 9..8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 control, 1 reload low, 2 reload high, 3 data) |
| wrData | input | 8 | Register write data |
| dacCode | output | 8 | Code to the converter channel |
| outEn | output | 1 | Channel output enable |
| hiZReq | output | 1 | Request to float the converter pad |

## Verification
The bound checker covers the behaviours that can be judged from a single cycle or from one cycle to the next:

- a disabled channel produces a zero code (R2);
- the direct path follows the data register (R3);
- tone samples are never zero (R4);
- the table address is parked at 0 in direct mode (R5);
- the address only ever moves by +1 mod 64 (R6).

The exact step timing cannot be checked cycle by cycle. The bench scenarios cover it instead:

- the 2·(L+1) period and the wrap after a long run;
- a deferred reload against an immediate one (R7, R8);
- full 10-bit reload values (R10);
- a data write during tone mode, which must not disturb the output (R9).

// File: rtl/subtone_pkg.sv
package subtone_pkg;
  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic run;      // tone mode active
    logic cntLoad;  // one-cycle pulse: reload the counter now
  } strb_t;
endpackage

// File: rtl/subtone_ctrl.sv
module subtone_ctrl
  import subtone_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned TMR_W = 10,
  parameter int unsigned RA_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [RA_W-1:0]  wrAddr,
  input  logic [DW-1:0]    wrData,
  output strb_t            strb,
  output logic             outEn,
  output logic [TMR_W-1:0] reloadVal,
  output logic [DW-1:0]    dacData
);
  localparam int unsigned HI_W = TMR_W - DW;

  localparam logic [RA_W-1:0] A_CTRL = RA_W'(0);
  localparam logic [RA_W-1:0] A_RLO  = RA_W'(1);
  localparam logic [RA_W-1:0] A_RHI  = RA_W'(2);
  localparam logic [RA_W-1:0] A_DATA = RA_W'(3);

  logic toneSel;
  logic loadNow;
  logic cntLoadQ;
  logic reloadWr;

  assign reloadWr = wrEn && ((wrAddr == A_RLO) || (wrAddr == A_RHI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toneSel   <= 1'b0;
      loadNow   <= 1'b0;
      outEn     <= 1'b0;
      reloadVal <= '0;
      dacData   <= '0;
      cntLoadQ  <= 1'b0;
    end else begin
      cntLoadQ <= reloadWr && loadNow;
      if (wrEn) begin
        unique case (wrAddr)
          A_CTRL: begin
            toneSel <= wrData[0];
            loadNow <= wrData[1];
            outEn   <= wrData[2];
          end
          A_RLO:   reloadVal[DW-1:0]     <= wrData;
          A_RHI:   reloadVal[TMR_W-1:DW] <= wrData[HI_W-1:0];
          A_DATA:  dacData               <= wrData;
          default: ;
        endcase
      end
    end
  end

  assign strb.run     = toneSel;
  assign strb.cntLoad = cntLoadQ;
endmodule

// File: rtl/subtone_dp.sv
module subtone_dp
  import subtone_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned TMR_W = 10,
  parameter int unsigned AW    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic             outEn,
  input  logic [TMR_W-1:0] reloadVal,
  input  logic [DW-1:0]    dacData,
  output logic [AW-1:0]    tblAddr,
  output logic [DW-1:0]    dacCode
);
  localparam int unsigned QW   = AW - 1;              // half-wave index width
  localparam int unsigned QTR  = 1 << (AW - 2);       // quarter-wave length
  localparam logic [DW-1:0] MID = DW'(1 << (DW - 1)); // mid-scale code

  logic             pre;
  logic [TMR_W-1:0] cnt;
  logic [DW-1:0]    sample;

  // Quarter-wave amplitude: round(127 * sin(2*pi*k/64)) for k = 0..16.
  function automatic logic [DW-1:0] quarterAmp(input logic [QW-1:0] k);
    unique case (k)
      5'd0:    quarterAmp = 8'd0;
      5'd1:    quarterAmp = 8'd12;
      5'd2:    quarterAmp = 8'd25;
      5'd3:    quarterAmp = 8'd37;
      5'd4:    quarterAmp = 8'd49;
      5'd5:    quarterAmp = 8'd60;
      5'd6:    quarterAmp = 8'd71;
      5'd7:    quarterAmp = 8'd81;
      5'd8:    quarterAmp = 8'd90;
      5'd9:    quarterAmp = 8'd98;
      5'd10:   quarterAmp = 8'd106;
      5'd11:   quarterAmp = 8'd112;
      5'd12:   quarterAmp = 8'd117;
      5'd13:   quarterAmp = 8'd122;
      5'd14:   quarterAmp = 8'd125;
      5'd15:   quarterAmp = 8'd126;
      default: quarterAmp = 8'd127;
    endcase
  endfunction

  // Full-wave sample built from the quarter wave by mirror and sign symmetry.
  function automatic logic [DW-1:0] sineAt(input logic [AW-1:0] idx);
    logic [QW-1:0] j;
    logic [QW-1:0] k;
    logic [DW-1:0] q;
    j = idx[QW-1:0];
    k = (j > QW'(QTR)) ? QW'((QTR * 2) - int'(j)) : j;
    q = quarterAmp(k);
    sineAt = idx[AW-1] ? (MID - q) : (MID + q);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre     <= 1'b0;
      cnt     <= '0;
      tblAddr <= '0;
    end else if (!strb.run) begin
      pre     <= 1'b0;
      cnt     <= reloadVal;
      tblAddr <= '0;
    end else if (strb.cntLoad) begin
      pre <= 1'b0;
      cnt <= reloadVal;
    end else begin
      pre <= ~pre;
      if (pre) begin
        if (cnt == '0) begin
          cnt     <= reloadVal;
          tblAddr <= tblAddr + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign sample  = sineAt(tblAddr);
  assign dacCode = !outEn ? '0 : (strb.run ? sample : dacData);
endmodule

// File: rtl/subtone_gen.sv
module subtone_gen
  import subtone_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned TMR_W = 10,
  parameter int unsigned AW    = 6,
  parameter int unsigned RA_W  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RA_W-1:0] wrAddr,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   dacCode,
  output logic            outEn,
  output logic            hiZReq
);
  strb_t            strb;
  logic [TMR_W-1:0] reloadVal;
  logic [DW-1:0]    dacData;
  logic [AW-1:0]    tblAddr;

  subtone_ctrl #(.DW(DW), .TMR_W(TMR_W), .RA_W(RA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .outEn(outEn), .reloadVal(reloadVal), .dacData(dacData)
  );

  subtone_dp #(.DW(DW), .TMR_W(TMR_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .outEn(outEn),
    .reloadVal(reloadVal), .dacData(dacData),
    .tblAddr(tblAddr), .dacCode(dacCode)
  );

  assign hiZReq = ~outEn;
endmodule

// File: rtl/subtone_chk.sv
module subtone_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] dacCode,
  input logic          outEn,
  input logic          run,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dacReg
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outEn && dacCode == '0));

  p_dark_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> dacCode == '0);

  p_direct_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !run) |-> dacCode == dacReg);

  p_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && run) |-> dacCode != '0);

  p_park_r5: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> addr == '0);

  p_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && addr != $past(addr)) |-> addr == AW'($past(addr) + 1'b1));
endmodule

bind subtone_gen subtone_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .dacCode(dacCode), .outEn(outEn),
  .run(strb.run), .addr(tblAddr), .dacReg(dacData)
);

// File: tb/test_subtone_gen.sv
`timescale 1ns/1ps
module test_subtone_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] dacCode;
  logic       outEn;
  logic       hiZReq;
  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  subtone_gen i_subtone_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dacCode(dacCode), .outEn(outEn), .hiZReq(hiZReq)
  );

  function automatic int sineExp(input int a);
    real s;
    int r;
    s = 127.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 64.0);
    if (s >= 0.0) r = $rtoi(s + 0.5);
    else          r = -$rtoi(-s + 0.5);
    return 128 + r;
  endfunction

  function automatic logic [7:0] ctrlByte(input bit tone, input bit ld, input bit oe);
    return {5'd0, oe, ld, tone};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setReload(input int l);
    wr(2'd1, 8'(l));
    wr(2'd2, 8'(l >> 8));
  endtask

  // Wait k-1 negedges, expect address a, then one more, expect a+1.
  task automatic stepAt(input int k, input int a, input string req);
    repeat (k - 1) @(negedge clk);
    check(req, dacCode, sineExp(a % 64));
    @(negedge clk);
    check(req, dacCode, sineExp((a + 1) % 64));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", dacCode, 0);
    check("R1", outEn, 0);
    check("R1", hiZReq, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", dacCode, 0);
    wr(2'd0, ctrlByte(0, 0, 1));
    check("R1", dacCode, 0);   // data register reset value
    check("R2", hiZReq, 0);

    // R3 direct mode with random bytes
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(2'd3, d);
      check("R3", dacCode, d);
    end

    // R2 disabled channel
    wr(2'd0, ctrlByte(0, 0, 0));
    check("R2", dacCode, 0);
    check("R2", hiZReq, 1);
    check("R2", outEn, 0);

    // R5/R6/R4: L=0, run past the wrap
    setReload(0);
    wr(2'd0, ctrlByte(1, 0, 1));
    check("R5", dacCode, sineExp(0));
    for (int s = 0; s < 70; s++) stepAt(2, s, "R6");

    // R6 random reload lengths
    for (int it = 0; it < 6; it++) begin
      int l;
      l = int'($urandom_range(1, 40));
      wr(2'd0, ctrlByte(0, 0, 1));
      setReload(l);
      wr(2'd0, ctrlByte(1, 0, 1));
      check("R5", dacCode, sineExp(0));
      for (int s = 0; s < 3; s++) stepAt(2 * (l + 1), s, "R6");
    end

    // R10 reload value above 255
    wr(2'd0, ctrlByte(0, 0, 1));
    setReload(300);
    wr(2'd0, ctrlByte(1, 0, 1));
    stepAt(602, 0, "R10");

    // R7 deferred reload
    wr(2'd0, ctrlByte(0, 0, 1));
    setReload(20);
    wr(2'd0, ctrlByte(1, 0, 1));
    stepAt(42, 0, "R7");
    wr(2'd1, 8'd6);                 // latch only
    stepAt(40, 1, "R7");            // old period finishes
    stepAt(14, 2, "R7");            // new period applies

    // R8 immediate reload
    wr(2'd0, ctrlByte(1, 1, 1));
    wr(2'd1, 8'd25);
    stepAt(53, 3, "R8");

    // R9 data write in tone mode is ignored
    wr(2'd3, 8'h5A);
    check("R9", dacCode, sineExp(4));
    wr(2'd0, ctrlByte(0, 0, 1));
    check("R9", dacCode, 8'h5A);

    // R2 disabled during tone mode
    wr(2'd0, ctrlByte(1, 0, 0));
    check("R2", dacCode, 0);
    check("R2", hiZReq, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule